// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block moves a byte stream between a device-side buffer and host memory by following a table of region descriptors kept in host memory. A call is either a fresh start or a continuation. A fresh start carries the table base address. Both kinds of call carry a direction and the number of bytes the device side wants moved.

The walker reads 8-byte descriptors through a single-beat read port. Each descriptor gives a region address, a byte count and an end-of-table flag. The walker then issues one burst request per chunk on a data port until the call's byte count is used up. A descriptor fetch happens only when the current region has no bytes left. The position inside a partly used region survives from one call to the next, so a device transfer can be served by several short calls.

Each call ends with exactly one one-cycle status pulse: done, exhausted or error. Exhausted means the table ran out before the byte count was met. The table walk never leaves one 4 KB window that starts at the base address.

Top module: `sgdma_walker`

## Requirements
- R1: After reset, `desc_req_o`, `mem_req_o`, `done_o`, `exh_o` and `err_o` are all low.
- R2: Descriptor format: bits [31:0] of `desc_rdata_i` are the region address and bits [63:32] are the size word. The first fetch after a fresh start is issued at `base_i`.
- R3: Each accepted descriptor fetch advances the fetch address by 8. Successive fetches within a walk read base, base+8, base+16, and so on.
- R4: The region byte count is bits [15:0] of the size word (`desc_rdata_i[47:32]`) with bit 0 forced to zero. A result of zero means 65536 bytes. Size-word bits [30:16] are ignored.
- R5: A descriptor is fetched only when the current region's remaining length is zero. Each burst length (`mem_len_o`) is the smaller of the bytes still owed to the call and the region's remaining bytes. After the burst, the region address rises by that length.
- R6: Bit 31 of the size word (`desc_rdata_i[63]`) marks the last descriptor. Once that region is used up, no further fetch is issued, and a call still owed bytes ends with `exh_o`.
- R7: No fetch is issued once the fetch address is 4096 or more bytes past the base. A call still owed bytes at that point ends with `exh_o`.
- R8: A continuation (`cont_i`) keeps the region address, remaining length, last flag and table position. Its first burst resumes where the previous call stopped, with no fetch.
- R9: A fresh start (`start_i`) clears the region state and reloads the table position from `base_i`, so the next fetch is at the base again.
- R10: `mem_we_o` equals the call's `dir_i`: 1 is a memory write (device to host) and 0 is a memory read (host to device).
- R11: A fetch or burst answered with its error input high ends the call with `err_o`. No further request is issued until the next call.
- R12: A call whose byte count is met ends with a one-cycle `done_o`. A call with a byte count of zero ends with `done_o` and issues no request. At most one of `done_o`, `exh_o` and `err_o` is high in any cycle.
- R13: A request, with its address and length, stays unchanged until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fresh-start call pulse (taken when idle) |
| cont_i | input | 1 | Continuation call pulse (taken when idle, start wins) |
| base_i | input | ADDR_W | Table base address for a fresh start |
| req_bytes_i | input | REQ_W | Bytes requested by the device side for this call |
| dir_i | input | 1 | 1 = device to host (memory write), 0 = host to device |
| desc_req_o | output | 1 | Descriptor read request |
| desc_addr_o | output | ADDR_W | Descriptor read address |
| desc_ack_i | input | 1 | Descriptor read answered this cycle |
| desc_err_i | input | 1 | Descriptor read failed (valid with ack) |
| desc_rdata_i | input | 64 | Descriptor contents (valid with ack) |
| mem_req_o | output | 1 | Data burst request |
| mem_we_o | output | 1 | Burst direction, 1 = write to memory |
| mem_addr_o | output | ADDR_W | Burst start address |
| mem_len_o | output | FIELD_W+1 | Burst length in bytes |
| mem_ack_i | input | 1 | Burst completed this cycle |
| mem_err_i | input | 1 | Burst failed (valid with ack) |
| done_o | output | 1 | Call finished with its byte count met |
| exh_o | output | 1 | Call ended because the table ran out |
| err_o | output | 1 | Call ended on a port error |

## Verification
The in-RTL properties watch several behaviours on every cycle: the fetch pointer steps by 8, no fetch follows a last descriptor or leaves the 4 KB window, requests hold steady until acknowledged, continuations leave the region untouched, and at most one status pulse fires at a time. Other behaviours can only be shown by the bench's scenarios. These are the length decoding of odd and zero size fields, the exact burst addresses and lengths when a call splits a region, the reload of the table on a fresh start, and which status ends each call.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVAL  = 2'd1,
      ST_FETCH = 2'd2,
      ST_MOVE  = 2'd3
   } sgw_state_e;

   localparam int unsigned DESC_BYTES = 8;
   localparam int unsigned DESC_BITS  = DESC_BYTES * 8;
   localparam int unsigned LAST_BIT   = DESC_BITS - 1;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned ALIGN_BITS = 1
) (
   input  logic [sgw_pkg::DESC_BITS-1:0] desc_i,
   output logic [ADDR_W-1:0]             addr_o,
   output logic [FIELD_W:0]              len_o,
   output logic                          last_o
);
   logic [FIELD_W-1:0] raw_len;
   logic [FIELD_W-1:0] masked_len;

   initial begin
      assert (FIELD_W >= 2 && FIELD_W <= 31) else $error("FIELD_W out of range");
      assert (ALIGN_BITS < FIELD_W) else $error("ALIGN_BITS too large");
      assert (ADDR_W >= 32 && ADDR_W <= 64) else $error("ADDR_W out of range");
   end

   assign raw_len = desc_i[32 +: FIELD_W];
   assign addr_o  = ADDR_W'(desc_i[31:0]);
   assign last_o  = desc_i[sgw_pkg::LAST_BIT];

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign masked_len = {raw_len[FIELD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end else begin : g_raw
         assign masked_len = raw_len;
      end
   endgenerate

   // zero count stands for the full field range
   assign len_o = (masked_len == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, masked_len};

   // R4: decoded length is never zero
   always_comb begin
      a_r4_len_nonzero: assert (len_o != '0);
   end
endmodule

// File: rtl/sgw_tbl_ptr.sv
module sgw_tbl_ptr #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              bound_o
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(sgw_pkg::DESC_BYTES);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(PAGE_BYTES);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] offset;

   initial begin
      assert (PAGE_BYTES >= 16 && (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ptr_q  <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         ptr_q  <= base_i;
      end else if (step_i) begin
         ptr_q <= ptr_q + STEP;
      end
   end

   assign offset  = ptr_q - base_q;
   assign bound_o = (offset >= LIMIT);
   assign ptr_o   = ptr_q;

   // R3: every accepted fetch moves the pointer by one descriptor
   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !load_i |=> ptr_o == $past(ptr_o) + STEP);
   // R9: a reload puts the pointer at the base
   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ptr_o == $past(base_i));
endmodule

// File: rtl/sgw_region.sv
module sgw_region #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned REQ_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              arm_i,
   input  logic [REQ_W-1:0]  req_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [FIELD_W:0]  ld_len_i,
   input  logic              ld_last_i,
   input  logic              consume_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [FIELD_W:0]  cur_len_o,
   output logic              cur_last_o,
   output logic [REQ_W-1:0]  remain_o,
   output logic [FIELD_W:0]  chunk_o
);
   localparam int unsigned LEN_W = FIELD_W + 1;
   localparam int unsigned CMP_W = (REQ_W > LEN_W) ? REQ_W : LEN_W;

   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic              last_q;
   logic [REQ_W-1:0]  remain_q;
   logic [CMP_W-1:0]  rem_x;
   logic [CMP_W-1:0]  len_x;

   initial begin
      assert (REQ_W >= 2) else $error("REQ_W too small");
   end

   assign rem_x   = CMP_W'(remain_q);
   assign len_x   = CMP_W'(len_q);
   assign chunk_o = (rem_x < len_x) ? LEN_W'(remain_q) : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         len_q    <= '0;
         last_q   <= 1'b0;
         remain_q <= '0;
      end else begin
         if (clear_i) begin
            addr_q <= '0;
            len_q  <= '0;
            last_q <= 1'b0;
         end else if (load_i) begin
            addr_q <= ld_addr_i;
            len_q  <= ld_len_i;
            last_q <= ld_last_i;
         end else if (consume_i) begin
            addr_q <= addr_q + ADDR_W'(chunk_o);
            len_q  <= len_q - chunk_o;
         end
         if (arm_i) begin
            remain_q <= req_i;
         end else if (consume_i) begin
            remain_q <= remain_q - REQ_W'(chunk_o);
         end
      end
   end

   assign cur_addr_o = addr_q;
   assign cur_len_o  = len_q;
   assign cur_last_o = last_q;
   assign remain_o   = remain_q;

   // R5: a burst never moves zero bytes
   a_r5_chunk_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      consume_i |-> chunk_o != '0);
   // R8: a continuation leaves the region untouched
   a_r8_cont_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i && !clear_i && !load_i && !consume_i |=>
         $stable(cur_addr_o) && $stable(cur_len_o) && $stable(cur_last_o));
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REQ_W      = 20,
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned ALIGN_BITS = 1,
   parameter int unsigned PAGE_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cont_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [REQ_W-1:0]  req_bytes_i,
   input  logic              dir_i,
   output logic              desc_req_o,
   output logic [ADDR_W-1:0] desc_addr_o,
   input  logic              desc_ack_i,
   input  logic              desc_err_i,
   input  logic [63:0]       desc_rdata_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [FIELD_W:0]  mem_len_o,
   input  logic              mem_ack_i,
   input  logic              mem_err_i,
   output logic              done_o,
   output logic              exh_o,
   output logic              err_o
);
   import sgw_pkg::*;

   sgw_state_e        state_q, state_d;
   logic              dir_q;
   logic              done_q, exh_q, err_q;
   logic              set_done, set_exh, set_err;
   logic              fresh, arm, desc_take, mem_take;
   logic [ADDR_W-1:0] dec_addr;
   logic [FIELD_W:0]  dec_len;
   logic              dec_last;
   logic [ADDR_W-1:0] ptr;
   logic              bound;
   logic [ADDR_W-1:0] cur_addr;
   logic [FIELD_W:0]  cur_len;
   logic              cur_last;
   logic [REQ_W-1:0]  remain;
   logic [FIELD_W:0]  chunk;

   sgw_desc_decode #(
      .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .ALIGN_BITS(ALIGN_BITS)
   ) u_dec (
      .desc_i(desc_rdata_i), .addr_o(dec_addr), .len_o(dec_len), .last_o(dec_last)
   );

   sgw_tbl_ptr #(
      .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(fresh), .base_i(base_i),
      .step_i(desc_take), .ptr_o(ptr), .bound_o(bound)
   );

   sgw_region #(
      .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .REQ_W(REQ_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .clear_i(fresh), .arm_i(arm), .req_i(req_bytes_i),
      .load_i(desc_take), .ld_addr_i(dec_addr), .ld_len_i(dec_len), .ld_last_i(dec_last),
      .consume_i(mem_take), .cur_addr_o(cur_addr), .cur_len_o(cur_len),
      .cur_last_o(cur_last), .remain_o(remain), .chunk_o(chunk)
   );

   assign fresh     = (state_q == ST_IDLE) && start_i;
   assign arm       = (state_q == ST_IDLE) && (start_i || cont_i);
   assign desc_take = (state_q == ST_FETCH) && desc_ack_i && !desc_err_i;
   assign mem_take  = (state_q == ST_MOVE) && mem_ack_i && !mem_err_i;

   always_comb begin
      state_d  = state_q;
      set_done = 1'b0;
      set_exh  = 1'b0;
      set_err  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (arm) state_d = ST_EVAL;
         end
         ST_EVAL: begin
            if (remain == '0) begin
               state_d  = ST_IDLE;
               set_done = 1'b1;
            end else if (cur_len != '0) begin
               state_d = ST_MOVE;
            end else if (cur_last || bound) begin
               state_d = ST_IDLE;
               set_exh = 1'b1;
            end else begin
               state_d = ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (desc_ack_i) begin
               state_d = desc_err_i ? ST_IDLE : ST_EVAL;
               set_err = desc_err_i;
            end
         end
         ST_MOVE: begin
            if (mem_ack_i) begin
               state_d = mem_err_i ? ST_IDLE : ST_EVAL;
               set_err = mem_err_i;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         exh_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= set_done;
         exh_q   <= set_exh;
         err_q   <= set_err;
         if (arm) dir_q <= dir_i;
      end
   end

   assign desc_req_o  = (state_q == ST_FETCH);
   assign desc_addr_o = ptr;
   assign mem_req_o   = (state_q == ST_MOVE);
   assign mem_we_o    = dir_q;
   assign mem_addr_o  = cur_addr;
   assign mem_len_o   = chunk;
   assign done_o      = done_q;
   assign exh_o       = exh_q;
   assign err_o       = err_q;

   // R6: no fetch is issued after a last descriptor
   a_r6_no_fetch_past_last: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_o |-> !cur_last);
   // R7: fetches stay inside the page window
   a_r7_fetch_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_o |-> !bound);
   // R5: fetch only with an empty region
   a_r5_fetch_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_o |-> cur_len == '0);
   // R13: requests hold until acknowledged
   a_r13_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_o && !desc_ack_i |=> desc_req_o && $stable(desc_addr_o));
   a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=>
         mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o) && $stable(mem_we_o));
   // R12: one status at a time
   a_r12_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, exh_o, err_o}));
   // R11: error leaves the ports quiet
   a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !desc_req_o && !mem_req_o);
endmodule

// File: tb/sgdma_walker_tb.sv
module sgdma_walker_tb_top;
   localparam logic [31:0] TBL_BASE = 32'h0000_8000;

   typedef struct packed {
      logic [31:0] size_w;
      logic [19:0] req;
      logic [16:0] exp_len;
      logic [1:0]  exp_out;
   } vec_t;

   // outcome codes: 1 done, 2 exhausted, 3 error
   localparam vec_t VECS [0:6] = '{
      '{32'h8000_0200, 20'h00100, 17'h00100, 2'd1},
      '{32'h8000_0200, 20'h00200, 17'h00200, 2'd1},
      '{32'h8000_0200, 20'h00300, 17'h00200, 2'd2},
      '{32'h8000_0201, 20'h00300, 17'h00200, 2'd2},
      '{32'h8000_0000, 20'h10000, 17'h10000, 2'd1},
      '{32'h8001_0000, 20'h20000, 17'h10000, 2'd2},
      '{32'h8000_0001, 20'h00040, 17'h00040, 2'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, cont_i = 1'b0, dir_i = 1'b0;
   logic [31:0] base_i = '0;
   logic [19:0] req_bytes_i = '0;
   logic        desc_req_o, mem_req_o, mem_we_o, done_o, exh_o, err_o;
   logic [31:0] desc_addr_o, mem_addr_o;
   logic [16:0] mem_len_o;
   logic        desc_ack_i = 1'b0, desc_err_i = 1'b0, mem_ack_i = 1'b0, mem_err_i = 1'b0;
   logic [63:0] desc_rdata_i = '0;

   logic [63:0] desc_mem [0:511];
   int          n_chk = 0, n_fail = 0;
   int          nfetch, nburst, outcome, hold_bad;
   logic [31:0] f_addr [0:7];
   logic [31:0] f_last, b_last;
   logic [31:0] b_addr [0:7];
   logic [16:0] b_len [0:7];
   logic        b_we [0:7];

   always #5 clk = ~clk;

   sgdma_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i), .base_i(base_i),
      .req_bytes_i(req_bytes_i), .dir_i(dir_i), .desc_req_o(desc_req_o),
      .desc_addr_o(desc_addr_o), .desc_ack_i(desc_ack_i), .desc_err_i(desc_err_i),
      .desc_rdata_i(desc_rdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .mem_ack_i(mem_ack_i),
      .mem_err_i(mem_err_i), .done_o(done_o), .exh_o(exh_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 512; k++) desc_mem[k] = '0;
   endtask

   task automatic run_call(input bit is_start, input logic [19:0] req, input bit dir,
                           input bit slow, input int err_f, input int err_m);
      bit          waited;
      logic [31:0] held;
      int          idx;
      nfetch = 0; nburst = 0; outcome = 0; hold_bad = 0; waited = 0; held = '0;
      @(negedge clk);
      start_i = is_start; cont_i = !is_start; base_i = TBL_BASE;
      req_bytes_i = req; dir_i = dir;
      @(negedge clk);
      start_i = 1'b0; cont_i = 1'b0;
      for (int cyc = 0; cyc < 20000 && outcome == 0; cyc++) begin
         desc_ack_i = 1'b0; desc_err_i = 1'b0; mem_ack_i = 1'b0; mem_err_i = 1'b0;
         if (done_o) outcome = 1;
         else if (exh_o) outcome = 2;
         else if (err_o) outcome = 3;
         else if (desc_req_o) begin
            if (slow && !waited) begin
               waited = 1; held = desc_addr_o;
            end else begin
               if (slow && held != desc_addr_o) hold_bad++;
               waited = 0;
               idx = int'((desc_addr_o - TBL_BASE) >> 3) & 511;
               desc_ack_i = 1'b1;
               desc_rdata_i = desc_mem[idx];
               desc_err_i = (nfetch == err_f);
               if (nfetch < 8) f_addr[nfetch] = desc_addr_o;
               f_last = desc_addr_o;
               nfetch++;
            end
         end else if (mem_req_o) begin
            if (slow && !waited) begin
               waited = 1; held = mem_addr_o;
            end else begin
               if (slow && held != mem_addr_o) hold_bad++;
               waited = 0;
               mem_ack_i = 1'b1;
               mem_err_i = (nburst == err_m);
               if (nburst < 8) begin
                  b_addr[nburst] = mem_addr_o; b_len[nburst] = mem_len_o; b_we[nburst] = mem_we_o;
               end
               b_last = mem_addr_o;
               nburst++;
            end
         end
         if (outcome == 0) @(negedge clk);
      end
      desc_ack_i = 1'b0; desc_err_i = 1'b0; mem_ack_i = 1'b0; mem_err_i = 1'b0;
      if (outcome == 0) chk(1'b0, "call timeout", 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!desc_req_o && !mem_req_o, "R1 requests idle", {desc_req_o, mem_req_o}, 0);
      chk(!done_o && !exh_o && !err_o, "R1 status idle", {done_o, exh_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!desc_req_o && !mem_req_o, "R1 idle after release", {desc_req_o, mem_req_o}, 0);

      // vector table: single-descriptor tables (R2 R4 R6 R10 R12)
      for (int i = 0; i < 7; i++) begin
         clear_mem();
         desc_mem[0] = {VECS[i].size_w, 32'h1000_0000 + 32'(i) * 32'h100};
         run_call(1'b1, VECS[i].req, i[0], 1'b0, -1, -1);
         chk(nfetch == 1 && f_addr[0] == TBL_BASE, "R2 fetch at base", f_addr[0], TBL_BASE);
         chk(nburst == 1 && b_addr[0] == 32'h1000_0000 + 32'(i) * 32'h100, "R2 region address",
             b_addr[0], 32'h1000_0000 + 32'(i) * 32'h100);
         chk(b_len[0] == VECS[i].exp_len, "R4 burst length", b_len[0], VECS[i].exp_len);
         chk(b_we[0] == i[0], "R10 direction", b_we[0], i[0]);
         chk(outcome == int'(VECS[i].exp_out), "R6 R12 outcome", outcome, VECS[i].exp_out);
      end

      // R3 R5 two descriptors walked in one call
      clear_mem();
      desc_mem[0] = {32'h0000_0100, 32'hA000_0000};
      desc_mem[1] = {32'h8000_0080, 32'hA000_4000};
      run_call(1'b1, 20'h180, 1'b1, 1'b0, -1, -1);
      chk(nfetch == 2 && f_addr[1] == TBL_BASE + 8, "R3 second fetch", f_addr[1], TBL_BASE + 8);
      chk(nburst == 2 && b_addr[1] == 32'hA000_4000 && b_len[1] == 17'h80, "R5 second burst",
          b_addr[1], 32'hA000_4000);
      chk(outcome == 1, "R12 multi done", outcome, 1);

      // R13 same walk with delayed acknowledges
      run_call(1'b1, 20'h180, 1'b1, 1'b1, -1, -1);
      chk(hold_bad == 0, "R13 request held", hold_bad, 0);
      chk(nburst == 2 && b_len[0] == 17'h100 && outcome == 1, "R13 slow result", b_len[0], 17'h100);

      // R8 split region across calls
      clear_mem();
      desc_mem[0] = {32'h8000_0200, 32'hB000_0000};
      run_call(1'b1, 20'h80, 1'b0, 1'b0, -1, -1);
      chk(b_addr[0] == 32'hB000_0000 && b_len[0] == 17'h80 && outcome == 1, "R5 first part",
          b_len[0], 17'h80);
      run_call(1'b0, 20'h100, 1'b0, 1'b0, -1, -1);
      chk(nfetch == 0, "R8 no refetch", nfetch, 0);
      chk(b_addr[0] == 32'hB000_0080 && b_len[0] == 17'h100, "R8 resume address", b_addr[0],
          32'hB000_0080);
      run_call(1'b0, 20'h100, 1'b0, 1'b0, -1, -1);
      chk(nfetch == 0 && b_addr[0] == 32'hB000_0180 && b_len[0] == 17'h80, "R6 tail burst",
          b_len[0], 17'h80);
      chk(outcome == 2, "R6 exhausted after last", outcome, 2);
      run_call(1'b1, 20'h40, 1'b0, 1'b0, -1, -1);
      chk(nfetch == 1 && f_addr[0] == TBL_BASE, "R9 refetch at base", f_addr[0], TBL_BASE);
      chk(b_addr[0] == 32'hB000_0000 && b_len[0] == 17'h40, "R9 region reset", b_addr[0],
          32'hB000_0000);

      // R7 page bound
      clear_mem();
      for (int k = 0; k < 512; k++) desc_mem[k] = {32'h0000_0002, 32'hC000_0000 + 32'(k) * 16};
      run_call(1'b1, 20'h10000, 1'b1, 1'b0, -1, -1);
      chk(nfetch == 512, "R7 fetch count", nfetch, 512);
      chk(f_last == TBL_BASE + 32'd4088, "R7 last fetch", f_last, TBL_BASE + 32'd4088);
      chk(nburst == 512 && b_last == 32'hC000_1FF0, "R7 last burst", b_last, 32'hC000_1FF0);
      chk(outcome == 2, "R7 exhausted", outcome, 2);

      // R12 zero request
      run_call(1'b1, 20'h0, 1'b0, 1'b0, -1, -1);
      chk(nfetch == 0 && nburst == 0 && outcome == 1, "R12 zero request", nfetch + nburst, 0);

      // R11 errors
      clear_mem();
      desc_mem[0] = {32'h8000_0100, 32'hD000_0000};
      run_call(1'b1, 20'h40, 1'b0, 1'b0, 0, -1);
      chk(outcome == 3 && nburst == 0, "R11 fetch error", outcome, 3);
      run_call(1'b1, 20'h40, 1'b1, 1'b0, -1, 0);
      chk(outcome == 3 && nburst == 1, "R11 burst error", outcome, 3);
      repeat (3) @(negedge clk);
      chk(!desc_req_o && !mem_req_o, "R11 quiet after error", {desc_req_o, mem_req_o}, 0);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule